// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block turns several reset sources into one system reset and a set of per-domain resets. Its sources are a cold-start input (power applied), an external reset pin, a watchdog that must be serviced periodically, a digitized supply level, and one request line per subsystem domain. The supply level is judged against two thresholds. The upper (exit) threshold governs release from power-on reset. The lower (entry) threshold governs loss of power. Between the two lies a dead band in which the supply state does not change.

Release from power-on reset waits until the supply has held at or above the exit level for a programmable number of consecutive cycles. Once running, a dip below the entry level is tolerated as a brownout if it is shorter than a programmable count. A longer dip drops the system back into reset and restarts the release delay. The external reset asserts every output at once, without waiting for a clock. Every output deasserts through a two-flop synchronizer after a minimum pulse width. A sticky cause register records what caused the last reset, and a clear strobe empties it.

Top module: `reset_hub`

## Requirements
- R1: The system reset stays asserted until `supply_lvl` has been at or above `EXIT_LVL` for `HOLD_CYC` consecutive clocks. Any clock below `EXIT_LVL` while held restarts the count.
- R2: Supply values from `ENTER_LVL` up to `EXIT_LVL`-1 neither advance the release count while held nor trigger reset while running (hysteresis band).
- R3: While running, fewer than `DIP_CYC` consecutive clocks below `ENTER_LVL` have no effect and reset the dip count. `DIP_CYC` consecutive clocks below assert the system reset, set the brownout cause bit and restart the R1 delay.
- R4: `ext_rst_n` low asserts `sys_rst_n` and every `dom_rst_n` bit immediately, without a clock edge.
- R5: If `wdt_kick` stays low for `WDT_CYC` consecutive clocks while the system runs, the system reset asserts and the watchdog cause bit is set. Holding `wdt_kick` high prevents this.
- R6: A pulse on `dom_req[i]` asserts only `dom_rst_n[i]`. The system reset, the other domains and `cause` are unchanged.
- R7: Every reset output stays low for at least `STRETCH_CYC`+1 clocks. It rises two clocks after its last hold condition ends.
- R8: `cause` bit 0 = power-on, bit 1 = external, bit 2 = watchdog, bit 3 = brownout. Bits are sticky. `cause_clr` clears them in one clock, and an event in the same clock wins over the clear.
- R9: `cold_rst_n` low sets `cause` to exactly 4'b0001 and holds every reset output low.
- R10: While the system reset is asserted, every domain reset is asserted too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous power-applied reset, active low |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| supply_lvl | input | LVL_W | Digitized supply level |
| wdt_kick | input | 1 | Watchdog service strobe |
| dom_req | input | NDOM | Per-domain reset requests |
| cause_clr | input | 1 | Clears the cause register |
| sys_rst_n | output | 1 | System reset, active low |
| dom_rst_n | output | NDOM | Domain resets, active low |
| cause | output | 4 | Sticky reset cause |

## Verification
The bench builds the block with `HOLD_CYC`=8, `DIP_CYC`=4, `WDT_CYC`=20, `STRETCH_CYC`=3, two domains, and thresholds 100 and 120. With these values, a dip one clock short of tripping and a dip that just trips both fit into a table of a dozen supply steps. A watchdog expiry and the full stretch-and-synchronize release are short enough to time exactly. Levels of 110 fall in the hysteresis band, and levels of 90 and 130 fall outside it on either side.

// File: rtl/reset_hub.sv
module reset_hub #(
  parameter int LVL_W       = 8,
  parameter int ENTER_LVL   = 100,
  parameter int EXIT_LVL    = 120,
  parameter int HOLD_CYC    = 1000,
  parameter int DIP_CYC     = 16,
  parameter int WDT_CYC     = 65536,
  parameter int STRETCH_CYC = 8,
  parameter int NDOM        = 4
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             ext_rst_n,
  input  logic [LVL_W-1:0] supply_lvl,
  input  logic             wdt_kick,
  input  logic [NDOM-1:0]  dom_req,
  input  logic             cause_clr,
  output logic             sys_rst_n,
  output logic [NDOM-1:0]  dom_rst_n,
  output logic [3:0]       cause
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(DIP_CYC + 1);
  localparam int WW = $clog2(WDT_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);

  logic          arst_n, above, below;
  logic          pwr_up, brown_trip, wdt_fire, sys_src, sys_hold;
  logic [HW-1:0] hold_cnt;
  logic [DW-1:0] dip_cnt;
  logic [WW-1:0] wdt_cnt;
  logic [SW-1:0] s_cnt;
  logic          s_q1, s_q2;

  assign arst_n     = cold_rst_n & ext_rst_n;
  assign above      = supply_lvl >= LVL_W'(EXIT_LVL);
  assign below      = supply_lvl <  LVL_W'(ENTER_LVL);
  assign brown_trip = pwr_up & below & (dip_cnt == DW'(DIP_CYC - 1));
  assign wdt_fire   = sys_rst_n & ~wdt_kick & (wdt_cnt == WW'(WDT_CYC - 1));
  assign sys_src    = ~pwr_up | wdt_fire;
  assign sys_hold   = sys_src | (s_cnt != '0);
  assign sys_rst_n  = s_q2;

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n) begin
      pwr_up   <= 1'b0;
      hold_cnt <= '0;
      dip_cnt  <= '0;
    end else if (!pwr_up) begin
      dip_cnt <= '0;
      if (!above)
        hold_cnt <= '0;
      else if (hold_cnt == HW'(HOLD_CYC - 1)) begin
        pwr_up   <= 1'b1;
        hold_cnt <= '0;
      end else
        hold_cnt <= hold_cnt + 1'b1;
    end else begin
      if (!below)
        dip_cnt <= '0;
      else if (brown_trip) begin
        pwr_up  <= 1'b0;
        dip_cnt <= '0;
      end else
        dip_cnt <= dip_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)
      wdt_cnt <= '0;
    else if (!sys_rst_n || wdt_kick || wdt_fire)
      wdt_cnt <= '0;
    else
      wdt_cnt <= wdt_cnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)
      s_cnt <= SW'(STRETCH_CYC);
    else if (sys_src)
      s_cnt <= SW'(STRETCH_CYC);
    else if (s_cnt != '0)
      s_cnt <= s_cnt - 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      s_q1 <= 1'b0;
      s_q2 <= 1'b0;
    end else begin
      s_q1 <= ~sys_hold;
      s_q2 <= s_q1 & ~sys_hold;
    end

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    logic [SW-1:0] d_cnt;
    logic          d_hold, d_q1, d_q2;

    assign d_hold       = dom_req[g] | (d_cnt != '0) | sys_hold;
    assign dom_rst_n[g] = d_q2;

    always_ff @(posedge clk or negedge arst_n)
      if (!arst_n)
        d_cnt <= SW'(STRETCH_CYC);
      else if (dom_req[g])
        d_cnt <= SW'(STRETCH_CYC);
      else if (d_cnt != '0)
        d_cnt <= d_cnt - 1'b1;

    always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) begin
        d_q1 <= 1'b0;
        d_q2 <= 1'b0;
      end else begin
        d_q1 <= ~d_hold;
        d_q2 <= d_q1 & ~d_hold;
      end
  end

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)
      cause <= 4'b0001;
    else
      cause <= (cause & {4{~cause_clr}}) | {brown_trip, wdt_fire, ~ext_rst_n, 1'b0};
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk #(
  parameter int NDOM        = 4,
  parameter int STRETCH_CYC = 8
) (
  input logic            clk,
  input logic            cold_rst_n,
  input logic            ext_rst_n,
  input logic            cause_clr,
  input logic            sys_rst_n,
  input logic [NDOM-1:0] dom_rst_n,
  input logic [3:0]      cause
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)
      low_cnt <= '0;
    else if (sys_rst_n)
      low_cnt <= '0;
    else if (low_cnt != 16'hFFFF)
      low_cnt <= low_cnt + 1'b1;

  a_r4_ext_forces_all: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !ext_rst_n |-> (!sys_rst_n && dom_rst_n == '0));

  a_r7_min_low_width: assert property (@(posedge clk) disable iff (!cold_rst_n || !ext_rst_n)
    $rose(sys_rst_n) |-> (low_cnt >= 16'(STRETCH_CYC)));

  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ($past(cold_rst_n) && !$past(cause_clr)) |-> ((cause & $past(cause)) == $past(cause)));

  a_r10_sys_covers_domains: assert property (@(posedge clk) disable iff (!cold_rst_n || !ext_rst_n)
    !sys_rst_n |-> (dom_rst_n == '0));
endmodule

bind reset_hub reset_hub_chk #(.NDOM(NDOM), .STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .ext_rst_n(ext_rst_n), .cause_clr(cause_clr),
  .sys_rst_n(sys_rst_n), .dom_rst_n(dom_rst_n), .cause(cause)
);

// File: tb/reset_hub_tb.sv
module reset_hub_tb;
  localparam int NDOM = 2;
  localparam int WDT  = 20;

  logic            clk = 1'b0;
  logic            cold_rst_n = 1'b0, ext_rst_n = 1'b1;
  logic [7:0]      supply_lvl = 8'd0;
  logic            wdt_kick = 1'b1, cause_clr = 1'b0;
  logic [NDOM-1:0] dom_req = '0;
  logic            sys_rst_n;
  logic [NDOM-1:0] dom_rst_n;
  logic [3:0]      cause;
  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  reset_hub #(.LVL_W(8), .ENTER_LVL(100), .EXIT_LVL(120), .HOLD_CYC(8), .DIP_CYC(4),
              .WDT_CYC(WDT), .STRETCH_CYC(3), .NDOM(NDOM)) u_dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .ext_rst_n(ext_rst_n), .supply_lvl(supply_lvl),
    .wdt_kick(wdt_kick), .dom_req(dom_req), .cause_clr(cause_clr),
    .sys_rst_n(sys_rst_n), .dom_rst_n(dom_rst_n), .cause(cause));

  // {level, cycles, expected sys_rst_n, expected cause}
  localparam logic [20:0] VEC [12] = '{
    {8'd130, 8'd5,  1'b0, 4'b0001},  // R1 too short
    {8'd110, 8'd20, 1'b0, 4'b0001},  // R2 band does not release
    {8'd130, 8'd7,  1'b0, 4'b0001},  // R1 count restarted
    {8'd130, 8'd10, 1'b1, 4'b0001},  // R1 released
    {8'd110, 8'd20, 1'b1, 4'b0001},  // R2 band does not trip
    {8'd90,  8'd3,  1'b1, 4'b0001},  // R3 short dip
    {8'd130, 8'd4,  1'b1, 4'b0001},
    {8'd90,  8'd3,  1'b1, 4'b0001},  // R3 dip count cleared
    {8'd130, 8'd2,  1'b1, 4'b0001},
    {8'd90,  8'd6,  1'b0, 4'b1001},  // R3 long dip
    {8'd130, 8'd6,  1'b0, 4'b1001},  // R3 delay restarted
    {8'd130, 8'd12, 1'b1, 4'b1001}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected<=5000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    step(3);
    check(sys_rst_n, 0, "R9 reset sys");
    check(dom_rst_n, 0, "R9 reset domains");
    check(cause, 4'b0001, "R9 reset cause");
    cold_rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      supply_lvl = VEC[i][20:13];
      step(int'(VEC[i][12:5]));
      check(sys_rst_n, VEC[i][4], $sformatf("R1/R2/R3 row %0d sys", i));
      check(cause, VEC[i][3:0], $sformatf("R3/R8 row %0d cause", i));
    end

    cause_clr = 1'b1; step(1); cause_clr = 1'b0;
    check(cause, 4'b0000, "R8 clear");

    // watchdog
    wdt_kick = 1'b0;
    step(WDT - 2);
    check(sys_rst_n, 1, "R5 before timeout");
    step(3);
    check(sys_rst_n, 0, "R5 timeout");
    check(dom_rst_n, 0, "R10 domains follow sys");
    check(cause, 4'b0100, "R5/R8 wdt cause");
    wdt_kick = 1'b1;
    step(3);
    check(sys_rst_n, 0, "R7 stretch");
    step(6);
    check(sys_rst_n, 1, "R7 release");

    // domain request
    dom_req = 2'b01; step(1); dom_req = 2'b00;
    check(dom_rst_n, 2'b10, "R6 own domain only");
    check(sys_rst_n, 1, "R6 sys untouched");
    step(2);
    check(dom_rst_n, 2'b10, "R7 domain stretch");
    step(4);
    check(dom_rst_n, 2'b11, "R7 domain release");
    check(cause, 4'b0100, "R6 cause unchanged");

    // external reset, asynchronous
    ext_rst_n = 1'b0;
    #1;
    check(sys_rst_n, 0, "R4 async sys");
    check(dom_rst_n, 0, "R4 async domains");
    @(negedge clk);
    cause_clr = 1'b1;
    step(1);
    cause_clr = 1'b0;
    check(cause, 4'b0010, "R8 event wins over clear");
    ext_rst_n = 1'b1;
    step(3);
    check(sys_rst_n, 0, "R7 ext stretch");
    step(3);
    check(sys_rst_n, 1, "R4 ext release");

    // cold restart
    cold_rst_n = 1'b0;
    step(2);
    check(cause, 4'b0001, "R9 cold cause only por");
    check(sys_rst_n, 0, "R9 cold sys");
    cold_rst_n = 1'b1;
    step(15);
    check(sys_rst_n, 1, "R1 cold release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule